// File: doc/BRIEF.md
# Codec Register Write Master (two-wire bus)

This block is a write-only master for a two-wire serial bus. It is used to load configuration registers in an audio codec. A single-cycle `start` request, accepted only while the block is idle, runs one fixed transaction:

1. A start condition.
2. The 7-bit target address followed by a write bit of 0.
3. A register index byte.
4. A data byte.
5. A stop condition.

The target must acknowledge each byte. The three byte values are captured when the request is accepted, so the inputs may change freely during the transfer. Both bus lines are open drain. The block reports each one as a "pull low" enable, and the pad merges it with the external pull-up. The pad returns the SDA level through `sda_in`.

Timing comes from a tick divider on the system clock. One tick lasts `TICK_CYCLES = ceil(CLK_HZ / (3*SCL_HZ))` system cycles, and every SCL bit lasts three ticks: two with SCL low and one with SCL high.

The state machine has these states, each lasting one tick:

| State | Bus action |
|---|---|
| `ST_IDLE` | Both lines released. Waits for `start`. |
| `ST_START_SETUP` | Both lines released, giving bus setup time. |
| `ST_START_HOLD` | SDA pulled low while SCL stays high. This is the start condition. |
| `ST_BIT_LOW_HOLD` | SCL goes low. SDA keeps its previous level (hold time). |
| `ST_BIT_LOW_SET` | SDA takes the new bit. |
| `ST_BIT_HIGH` | SCL released. SDA is frozen. |
| `ST_ACK_LOW_HOLD` | SCL goes low for the acknowledge slot. SDA keeps its level. |
| `ST_ACK_LOW_REL` | SDA released so the target can drive it. |
| `ST_ACK_HIGH` | SCL released. The acknowledge is sampled on the tick that ends this state. |
| `ST_STOP_LOW_HOLD` | SCL low. SDA keeps its level. |
| `ST_STOP_LOW_SET` | SDA pulled low. |
| `ST_STOP_HIGH` | SCL released with SDA still low. |
| `ST_STOP_DONE` | SDA released while SCL is high. This is the stop condition. |

The transitions are:

- `ST_IDLE` → `ST_START_SETUP` on an accepted start.
- `ST_START_SETUP` → `ST_START_HOLD` → `ST_BIT_LOW_HOLD`.
- `ST_BIT_LOW_HOLD` → `ST_BIT_LOW_SET` → `ST_BIT_HIGH`.
- `ST_BIT_HIGH` → `ST_BIT_LOW_HOLD` while bits remain in the byte, or → `ST_ACK_LOW_HOLD` after bit 0.
- `ST_ACK_LOW_HOLD` → `ST_ACK_LOW_REL` → `ST_ACK_HIGH`.
- `ST_ACK_HIGH` → `ST_BIT_LOW_HOLD` on an acknowledge with bytes remaining. It goes → `ST_STOP_LOW_HOLD` on a missing acknowledge or after the last byte.
- `ST_STOP_LOW_HOLD` → `ST_STOP_LOW_SET` → `ST_STOP_HIGH` → `ST_STOP_DONE` → `ST_IDLE`, with a `done` pulse on the last step.

Top module: `codec_cfg_writer`

## Requirements
- R1: After reset and whenever idle, `busy`, `done` and `ack_error` are 0 and both `scl_drive_low` and `sda_drive_low` are 0 (lines released).
- R2: An accepted request sends exactly three bytes, MSB first. Byte 0 is `{dev_addr, 1'b0}`, byte 1 is `reg_addr` and byte 2 is `data`, each followed by an acknowledge clock.
- R3: Within a transaction, SDA changes while SCL is high exactly twice: one fall (start, before the first SCL fall) and one rise (stop, at the end). All other SDA changes occur with SCL low.
- R4: Consecutive SCL rising edges in a transaction are exactly `3*TICK_CYCLES` system cycles apart (315 at 125 MHz and 400 kHz).
- R5: During each ninth clock the master releases SDA. A low level sampled there is an acknowledge, and the transfer continues with the next byte.
- R6: A high level in an acknowledge slot sets `ack_error`, sends no further byte, and goes straight to the stop sequence followed by `done`.
- R7: `busy` is 1 from the cycle after the request is accepted until `done`. `done` is a one-cycle pulse, in the cycle in which `busy` is already 0.
- R8: A `start` while `busy` is 1 is ignored. The bytes sent are the input values captured in the accepting cycle, even if the inputs change later.
- R9: `ack_error` keeps its value after `done` and is cleared only when the next request is accepted.
- R10: A request present in the cycle where `done` pulses is accepted at once, giving back-to-back transactions with one start condition each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transaction request, taken only while idle |
| dev_addr | input | 7 | Target device address |
| reg_addr | input | 8 | Register index byte |
| data | input | 8 | Register value byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| ack_error | output | 1 | A byte was not acknowledged in the last transaction |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | SDA level seen at the pad |

## Verification
Two functions can fall in the same cycle: the `done` pulse that closes one transaction and the acceptance of the next request. The bench provokes this by raising `start` midway through a transfer, with new byte values, and holding it there. The first transfer must ignore the request and still send its own captured bytes. In the `done` cycle the held request must then be accepted, so that `busy` is high in the next cycle. The second transfer must carry the new bytes, with exactly one start and one stop condition on the bus for each transfer.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_SETUP,
        ST_START_HOLD,
        ST_BIT_LOW_HOLD,
        ST_BIT_LOW_SET,
        ST_BIT_HIGH,
        ST_ACK_LOW_HOLD,
        ST_ACK_LOW_REL,
        ST_ACK_HIGH,
        ST_STOP_LOW_HOLD,
        ST_STOP_LOW_SET,
        ST_STOP_HIGH,
        ST_STOP_DONE
    } cfgw_state_e;

    localparam int unsigned CFGW_BYTES  = 3;
    localparam int unsigned CFGW_BITS   = 8;
    localparam int unsigned CFGW_PHASES = 3;

    // cycles per sub-phase, rounded up so SCL never exceeds the target rate
    function automatic int unsigned cfgw_tick_cycles(input int unsigned clk_hz,
                                                     input int unsigned scl_hz);
        return (clk_hz + CFGW_PHASES * scl_hz - 1) / (CFGW_PHASES * scl_hz);
    endfunction

endpackage

// File: rtl/cfgw_tick.sv
module cfgw_tick #(
    parameter int unsigned TICK_CYCLES = 105
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = $clog2(TICK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/cfgw_sync.sv
module cfgw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= {pipe_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/cfgw_byte_sel.sv
module cfgw_byte_sel #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned NBYTES = 3
) (
    input  logic [ADDR_W-1:0]         dev_addr,
    input  logic [BYTE_W-1:0]         reg_addr,
    input  logic [BYTE_W-1:0]         data,
    input  logic [$clog2(NBYTES)-1:0] byte_idx,
    input  logic [$clog2(BYTE_W)-1:0] bit_idx,
    output logic                      bit_o
);
    logic [BYTE_W-1:0] frame [NBYTES];

    // byte 0 carries the write flag (0) in its least significant bit
    assign frame[0] = {dev_addr, 1'b0};
    assign frame[1] = reg_addr;

    generate
        for (genvar k = 2; k < NBYTES; k++) begin : g_tail
            assign frame[k] = data;
        end
    endgenerate

    assign bit_o = frame[byte_idx][bit_idx];

endmodule

// File: rtl/codec_cfg_writer.sv
module codec_cfg_writer
    import cfgw_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000,
    parameter int unsigned SCL_HZ = 400_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [6:0] dev_addr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] data,
    output logic       busy,
    output logic       done,
    output logic       ack_error,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic       sda_in
);
    localparam int unsigned TICK_CYCLES = cfgw_tick_cycles(CLK_HZ, SCL_HZ);
    localparam int unsigned BIT_W       = $clog2(CFGW_BITS);
    localparam int unsigned IDX_W       = $clog2(CFGW_BYTES);
    localparam logic [BIT_W-1:0] TOP_BIT   = BIT_W'(CFGW_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(CFGW_BYTES - 1);

    cfgw_state_e state_q, state_d;

    logic [BIT_W-1:0] bit_q;
    logic [IDX_W-1:0] byte_q;
    logic [6:0]       dev_q;
    logic [7:0]       reg_q;
    logic [7:0]       dat_q;
    logic             ack_error_q;
    logic             done_q;
    logic             scl_low_q;
    logic             sda_low_q;
    logic             tick;
    logic             sda_sync;
    logic             cur_bit;
    logic             accept;
    logic             nack;

    assign busy   = (state_q != ST_IDLE);
    assign accept = (state_q == ST_IDLE) && start;
    assign nack   = sda_sync;

    cfgw_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    cfgw_sync #(.STAGES(2)) u_sda_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sda_in),
        .q    (sda_sync)
    );

    cfgw_byte_sel #(.ADDR_W(7), .BYTE_W(CFGW_BITS), .NBYTES(CFGW_BYTES)) u_byte_sel (
        .dev_addr(dev_q),
        .reg_addr(reg_q),
        .data    (dat_q),
        .byte_idx(byte_q),
        .bit_idx (bit_q),
        .bit_o   (cur_bit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (state_q == ST_IDLE) begin
            if (start) state_d = ST_START_SETUP;
        end else if (tick) begin
            unique case (state_q)
                ST_START_SETUP:   state_d = ST_START_HOLD;
                ST_START_HOLD:    state_d = ST_BIT_LOW_HOLD;
                ST_BIT_LOW_HOLD:  state_d = ST_BIT_LOW_SET;
                ST_BIT_LOW_SET:   state_d = ST_BIT_HIGH;
                ST_BIT_HIGH:      state_d = (bit_q == '0) ? ST_ACK_LOW_HOLD : ST_BIT_LOW_HOLD;
                ST_ACK_LOW_HOLD:  state_d = ST_ACK_LOW_REL;
                ST_ACK_LOW_REL:   state_d = ST_ACK_HIGH;
                ST_ACK_HIGH:      state_d = (nack || byte_q == LAST_BYTE) ? ST_STOP_LOW_HOLD
                                                                          : ST_BIT_LOW_HOLD;
                ST_STOP_LOW_HOLD: state_d = ST_STOP_LOW_SET;
                ST_STOP_LOW_SET:  state_d = ST_STOP_HIGH;
                ST_STOP_HIGH:     state_d = ST_STOP_DONE;
                ST_STOP_DONE:     state_d = ST_IDLE;
                default:          state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit/byte sequencing, captured request, status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q       <= TOP_BIT;
            byte_q      <= '0;
            dev_q       <= '0;
            reg_q       <= '0;
            dat_q       <= '0;
            ack_error_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                dev_q       <= dev_addr;
                reg_q       <= reg_addr;
                dat_q       <= data;
                ack_error_q <= 1'b0;
                bit_q       <= TOP_BIT;
                byte_q      <= '0;
            end else if (tick) begin
                unique case (state_q)
                    ST_BIT_HIGH: begin
                        if (bit_q != '0) bit_q <= bit_q - 1'b1;
                    end
                    ST_ACK_HIGH: begin
                        if (nack) begin
                            ack_error_q <= 1'b1;
                        end else if (byte_q != LAST_BYTE) begin
                            byte_q <= byte_q + 1'b1;
                            bit_q  <= TOP_BIT;
                        end
                    end
                    ST_STOP_DONE: done_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // registered bus outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
        end else begin
            unique case (state_d)
                ST_IDLE, ST_START_SETUP, ST_STOP_DONE: begin
                    scl_low_q <= 1'b0;
                    sda_low_q <= 1'b0;
                end
                ST_START_HOLD: begin
                    scl_low_q <= 1'b0;
                    sda_low_q <= 1'b1;
                end
                ST_BIT_LOW_HOLD, ST_ACK_LOW_HOLD, ST_STOP_LOW_HOLD: begin
                    scl_low_q <= 1'b1;
                end
                ST_BIT_LOW_SET: begin
                    scl_low_q <= 1'b1;
                    sda_low_q <= !cur_bit;
                end
                ST_ACK_LOW_REL: begin
                    scl_low_q <= 1'b1;
                    sda_low_q <= 1'b0;
                end
                ST_STOP_LOW_SET: begin
                    scl_low_q <= 1'b1;
                    sda_low_q <= 1'b1;
                end
                ST_BIT_HIGH, ST_ACK_HIGH, ST_STOP_HIGH: begin
                    scl_low_q <= 1'b0;
                end
                default: begin
                    scl_low_q <= 1'b0;
                    sda_low_q <= 1'b0;
                end
            endcase
        end
    end

    assign scl_drive_low = scl_low_q;
    assign sda_drive_low = sda_low_q;
    assign done          = done_q;
    assign ack_error     = ack_error_q;

    // ---------------- assertions ----------------
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_drive_low && !sda_drive_low));

    p_sda_frozen_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_BIT_HIGH, ST_ACK_HIGH, ST_STOP_HIGH}) |-> $stable(sda_drive_low));

    p_scl_low_on_data_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT_LOW_SET) |-> scl_drive_low);

    p_ack_slot_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_HIGH) |-> !sda_drive_low);

    p_nack_to_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_HIGH && tick && sda_sync) |=> (state_q == ST_STOP_LOW_HOLD && ack_error));

    p_done_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_ignored_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(dev_q) && $stable(reg_q) && $stable(dat_q)));

    p_error_held_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(ack_error));

endmodule

// File: tb/test_codec_cfg_writer.sv
`timescale 1ns/1ps
module test_codec_cfg_writer;

    localparam int CLK_HZ = 125_000_000;
    localparam int SCL_HZ = 400_000;
    localparam int TICK   = (CLK_HZ + 3 * SCL_HZ - 1) / (3 * SCL_HZ);
    localparam int PERIOD = 3 * TICK;
    localparam int NVEC   = 6;

    // {dev_addr[6:0], reg_addr[7:0], data[7:0], nack_per_byte[2:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {7'h1A, 8'h06, 8'h00, 3'b000},
        {7'h7F, 8'hFF, 8'hFF, 3'b000},
        {7'h00, 8'h00, 8'h01, 3'b000},
        {7'h55, 8'hA5, 8'h5A, 3'b001},
        {7'h2B, 8'h10, 8'h3C, 3'b010},
        {7'h1A, 8'h0F, 8'h81, 3'b100}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] dev_addr = '0;
    logic [7:0] reg_addr = '0;
    logic [7:0] data = '0;
    logic       busy, done, ack_error, scl_drive_low, sda_drive_low;
    logic       slave_low = 1'b0;
    logic [2:0] nack_plan = 3'b000;
    logic       scl_line, sda_line;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    assign scl_line = !scl_drive_low;
    assign sda_line = !(sda_drive_low || slave_low);

    codec_cfg_writer #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) i_codec_cfg_writer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .dev_addr     (dev_addr),
        .reg_addr     (reg_addr),
        .data         (data),
        .busy         (busy),
        .done         (done),
        .ack_error    (ack_error),
        .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low),
        .sda_in       (sda_line)
    );

    // ---------------- bus monitor and target model ----------------
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    int         mon_bits = 0, mon_nbytes = 0, mon_starts = 0, mon_stops = 0;
    int         mon_period_bad = 0, mon_last_rise = -1;
    logic [7:0] mon_shift = '0;
    logic [7:0] mon_bytes [4];
    logic [3:0] mon_acked = '0;

    always @(negedge clk) begin
        cyc++;
        if (scl_line && prev_scl && (sda_line != prev_sda)) begin
            if (!sda_line) begin
                mon_starts++;
                mon_bits = 0;
                mon_nbytes = 0;
                mon_last_rise = -1;
                mon_acked = '0;
            end else begin
                mon_stops++;
            end
        end
        if (scl_line && !prev_scl) begin
            if (mon_last_rise >= 0 && (cyc - mon_last_rise) != PERIOD) mon_period_bad++;
            mon_last_rise = cyc;
            if (mon_bits < 8) begin
                mon_shift = {mon_shift[6:0], sda_line};
                mon_bits++;
            end else begin
                if (mon_nbytes < 4) begin
                    mon_bytes[mon_nbytes] = mon_shift;
                    mon_acked[mon_nbytes] = !sda_line;
                end
                mon_nbytes++;
                mon_bits = 0;
            end
        end
        if (!scl_line && prev_scl) begin
            if (mon_bits == 8 && mon_nbytes < 3 && !nack_plan[mon_nbytes]) slave_low <= 1'b1;
            else slave_low <= 1'b0;
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    // ---------------- watchdog ----------------
    always @(negedge clk) begin
        if (cyc > 190_000) begin
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [6:0] d, input logic [7:0] r,
                                            input logic [7:0] v, input int k);
        if (k == 0) return {d, 1'b0};
        if (k == 1) return r;
        return v;
    endfunction

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 12000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // checks on one finished transaction, sampled in the done cycle
    task automatic judge(input logic [6:0] d, input logic [7:0] r, input logic [7:0] v,
                         input logic [2:0] nk, input int s0, input int p0, input int pb0);
        int first = 3;
        for (int k = 2; k >= 0; k--) if (nk[k]) first = k;
        chk("R7", "busy low with done", {31'b0, busy}, 32'd0);
        chk("R6", "ack_error", {31'b0, ack_error}, (first < 3) ? 32'd1 : 32'd0);
        chk("R2", "bytes sent", mon_nbytes, (first < 3) ? first + 1 : 3);
        for (int k = 0; k < 3; k++) begin
            if (k < mon_nbytes && k <= first)
                chk("R2", "byte value", {24'b0, mon_bytes[k]}, {24'b0, exp_byte(d, r, v, k)});
        end
        for (int k = 0; k < 3; k++) begin
            if (k < first && k < mon_nbytes)
                chk("R5", "ack seen", {31'b0, mon_acked[k]}, 32'd1);
        end
        chk("R3", "start conditions", mon_starts - s0, 32'd1);
        chk("R3", "stop conditions", mon_stops - p0, 32'd1);
        chk("R4", "scl period faults", mon_period_bad - pb0, 32'd0);
    endtask

    task automatic run_txn(input logic [25:0] vec);
        int s0, p0, pb0, n;
        nack_plan = vec[2:0];
        s0 = mon_starts; p0 = mon_stops; pb0 = mon_period_bad;
        @(negedge clk);
        dev_addr = vec[25:19]; reg_addr = vec[18:11]; data = vec[10:3];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7", "busy after accept", {31'b0, busy}, 32'd1);
        wait_done(n);
        chk("R7", "done reached", {31'b0, done}, 32'd1);
        judge(vec[25:19], vec[18:11], vec[10:3], vec[2:0], s0, p0, pb0);
        @(negedge clk);
        chk("R7", "done one cycle", {31'b0, done}, 32'd0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        int n, s0, p0, pb0;
        repeat (5) @(negedge clk);
        chk("R1", "busy in reset", {31'b0, busy}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "busy idle", {31'b0, busy}, 32'd0);
        chk("R1", "done idle", {31'b0, done}, 32'd0);
        chk("R1", "ack_error idle", {31'b0, ack_error}, 32'd0);
        chk("R1", "lines released", {30'b0, scl_drive_low, sda_drive_low}, 32'd0);

        // table of vectors
        for (int i = 0; i < NVEC; i++) run_txn(VEC[i]);

        // R9: error held while idle, then cleared by the next accepted request
        run_txn({7'h3C, 8'h01, 8'h02, 3'b001});
        repeat (500) @(negedge clk);
        chk("R9", "ack_error held", {31'b0, ack_error}, 32'd1);
        chk("R1", "lines released after", {30'b0, scl_drive_low, sda_drive_low}, 32'd0);
        @(negedge clk);
        dev_addr = 7'h11; reg_addr = 8'h22; data = 8'h33; nack_plan = 3'b000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "ack_error cleared on accept", {31'b0, ack_error}, 32'd0);
        wait_done(n);
        chk("R9", "ack_error after good txn", {31'b0, ack_error}, 32'd0);
        repeat (20) @(negedge clk);

        // R8 and R10: request held through a transfer, taken in the done cycle
        nack_plan = 3'b000;
        s0 = mon_starts; p0 = mon_stops; pb0 = mon_period_bad;
        @(negedge clk);
        dev_addr = 7'h4D; reg_addr = 8'h96; data = 8'hC3;
        start = 1'b1;
        @(negedge clk);
        repeat (3000) @(negedge clk);
        dev_addr = 7'h32; reg_addr = 8'h69; data = 8'h3C;
        wait_done(n);
        chk("R10", "done with held request", {31'b0, done}, 32'd1);
        judge(7'h4D, 8'h96, 8'hC3, 3'b000, s0, p0, pb0);
        chk("R8", "first byte kept", {24'b0, mon_bytes[0]}, {24'b0, 8'h9A});
        s0 = mon_starts; p0 = mon_stops; pb0 = mon_period_bad;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "busy right after done cycle", {31'b0, busy}, 32'd1);
        wait_done(n);
        chk("R10", "second done", {31'b0, done}, 32'd1);
        judge(7'h32, 8'h69, 8'h3C, 3'b000, s0, p0, pb0);
        repeat (20) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule